// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiplier

This block is the multiply stage of a 16-bit DSP datapath. It accepts two 16-bit operands, each with its own signedness flag, and produces a 40-bit product one clock later that can go straight into a wide accumulator. The block widens each operand by one bit, using a copy of bit 15 for a signed operand and a zero for an unsigned one. Signed by signed, unsigned by unsigned and both mixed-sign combinations therefore all run through one signed 17 by 17 multiplier array.

A mode flag picks integer or fractional (1.15) interpretation. In fractional mode the raw product is moved up by one bit so that the binary point lines up with a 1.31 result. Because the array is 17 bits wide and the result is wider than 32 bits, the product of -1.0 and -1.0 comes out as an exact +1.0 and does not wrap to a negative value. Accumulation, saturation, rounding and register-file access belong to the stages around this one.

Top module: `mxm_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_prod` is zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: With both signedness flags at 1 (operands read as two's complement) and `frac_mode` at 0, `out_prod` is the exact product, sign-extended to 40 bits.
- R4: With both signedness flags at 0 (operands read as unsigned), `out_prod` is the exact product and its bits 39 down to 33 are zero.
- R5: With exactly one signedness flag at 1, that operand is read as two's complement and the other as unsigned, and `out_prod` is the exact product, sign-extended to 40 bits.
- R6: With `frac_mode` at 1, `out_prod` is the product of R3 to R5 multiplied by two (shifted left one bit), so bit 0 is always 0.
- R7: In fractional mode with both operands signed and both equal to 0x8000 (-1.0), `out_prod` is 0x0080000000 (+1.0 in 1.31 form, sign bit clear).
- R8: In a cycle after `in_valid` was low, `out_prod` keeps the value it had before.
- R9: If either operand is 0x0000, `out_prod` is zero in every signedness and mode combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and flags present this cycle |
| a_data | input | 16 | First operand |
| b_data | input | 16 | Second operand |
| a_signed | input | 1 | 1: first operand is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: second operand is two's complement; 0: unsigned |
| frac_mode | input | 1 | 1: fractional 1.15 operands, product doubled; 0: integer |
| out_valid | output | 1 | Product register was loaded on the last edge |
| out_prod | output | 40 | Registered product, extended to 40 bits |

## Verification
A wrong extension bit on one operand shows up at the ports on the very next cycle as a product that differs in its upper bits. This is clearest for operands with bit 15 set, such as 0xFFFF times 0xFFFF, where the signed and unsigned readings differ by a large amount. A missing or doubled fractional shift shows on the next result as a factor of two, or as a set bit 0. A narrowed result path shows as the -1.0 by -1.0 case coming out negative. Any slip in the valid pipeline or the hold behaviour shows within one cycle, because the reference model is compared with both outputs on every clock, including idle cycles.

// File: rtl/mxm_pkg.sv
package mxm_pkg;

  // Per-operand signedness combination, first operand in the upper bit.
  typedef enum logic [1:0] {
    SGN_UU = 2'b00,
    SGN_US = 2'b01,
    SGN_SU = 2'b10,
    SGN_SS = 2'b11
  } sign_mode_e;

  // True when at least one operand is read as two's complement.
  function automatic logic mode_has_sign(sign_mode_e m);
    return (m != SGN_UU);
  endfunction

endpackage

// File: rtl/mxm_operand_ext.sv
module mxm_operand_ext #(
  parameter int unsigned OPND_W = 16
) (
  input  logic [OPND_W-1:0]      opnd,
  input  logic                   is_signed,
  output logic signed [OPND_W:0] ext
);

  // One extra top bit: a copy of the operand's MSB when signed, zero otherwise.
  logic top_bit;

  always_comb begin
    top_bit = is_signed ? opnd[OPND_W-1] : 1'b0;
    ext     = $signed({top_bit, opnd});
  end

endmodule

// File: rtl/mxm_core.sv
module mxm_core #(
  parameter int unsigned EXT_W = 17
) (
  input  logic signed [EXT_W-1:0]   x_in,
  input  logic signed [EXT_W-1:0]   y_in,
  output logic signed [2*EXT_W-1:0] prod
);

  localparam int unsigned PROD_W = 2 * EXT_W;

  logic signed [PROD_W-1:0] x_wide;
  logic signed [PROD_W-1:0] y_wide;

  // Widen explicitly so the array works on full-width signed values.
  always_comb begin
    x_wide = $signed({{EXT_W{x_in[EXT_W-1]}}, x_in});
    y_wide = $signed({{EXT_W{y_in[EXT_W-1]}}, y_in});
    prod   = x_wide * y_wide;
  end

endmodule

// File: rtl/mxm_align.sv
module mxm_align #(
  parameter int unsigned PROD_W = 34,
  parameter int unsigned OUT_W  = 40
) (
  input  logic signed [PROD_W-1:0] prod,
  input  logic                     frac,
  input  logic                     fill_sign,
  output logic [OUT_W-1:0]         result
);

  localparam int unsigned SH_W  = PROD_W + 1;
  localparam int unsigned PAD_W = OUT_W - SH_W;

  logic [SH_W-1:0] shifted;
  logic            fill;

  always_comb begin
    // Fractional: move the binary point up one place. Integer: widen only.
    if (frac) begin
      shifted = {prod, 1'b0};
    end else begin
      shifted = {prod[PROD_W-1], prod};
    end
    fill   = fill_sign & shifted[SH_W-1];
    result = {{PAD_W{fill}}, shifted};
  end

endmodule

// File: rtl/mxm_top.sv
module mxm_top #(
  parameter int unsigned OPND_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPND_W-1:0] a_data,
  input  logic [OPND_W-1:0] b_data,
  input  logic              a_signed,
  input  logic              b_signed,
  input  logic              frac_mode,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_prod
);
  import mxm_pkg::*;

  localparam int unsigned EXT_W  = OPND_W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;
  localparam int unsigned N_OPND = 2;

  logic [OPND_W-1:0]       opnd_raw [N_OPND];
  logic                    opnd_sgn [N_OPND];
  logic signed [EXT_W-1:0] opnd_ext [N_OPND];
  logic signed [PROD_W-1:0] raw_prod;
  logic [ACC_W-1:0]        aligned;
  sign_mode_e              smode;

  always_comb begin
    opnd_raw[0] = a_data;
    opnd_raw[1] = b_data;
    opnd_sgn[0] = a_signed;
    opnd_sgn[1] = b_signed;
    smode       = sign_mode_e'({a_signed, b_signed});
  end

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_ext
    mxm_operand_ext #(.OPND_W(OPND_W)) u_ext (
      .opnd      (opnd_raw[gi]),
      .is_signed (opnd_sgn[gi]),
      .ext       (opnd_ext[gi])
    );
  end

  mxm_core #(.EXT_W(EXT_W)) u_core (
    .x_in (opnd_ext[0]),
    .y_in (opnd_ext[1]),
    .prod (raw_prod)
  );

  mxm_align #(.PROD_W(PROD_W), .OUT_W(ACC_W)) u_align (
    .prod      (raw_prod),
    .frac      (frac_mode),
    .fill_sign (mode_has_sign(smode)),
    .result    (aligned)
  );

  // Output register: loads on a valid operand pair, holds otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_prod <= aligned;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> out_valid); // R2
  AST_VALID_ONLY_AFTER_IN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_prod)); // R8
  AST_UNSIGNED_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(a_signed) && !$past(b_signed))
      |-> (out_prod[ACC_W-1:PROD_W-1] == '0)); // R4
  AST_FRAC_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(frac_mode)) |-> !out_prod[0]); // R6
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && (($past(a_data) == '0) || ($past(b_data) == '0)))
      |-> (out_prod == '0)); // R9
  AST_MINUS_ONE_SQUARED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(frac_mode) && $past(a_signed) && $past(b_signed)
      && ($past(a_data) == {1'b1, {(OPND_W-1){1'b0}}})
      && ($past(b_data) == {1'b1, {(OPND_W-1){1'b0}}}))
      |-> (!out_prod[ACC_W-1] && out_prod[2*OPND_W-1] && (out_prod[2*OPND_W-2:0] == '0))); // R7

endmodule

// File: tb/mxm_top_bench.sv
`timescale 1ns/1ps
module mxm_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] a_data = '0;
  logic [15:0] b_data = '0;
  logic        a_signed = 1'b0;
  logic        b_signed = 1'b0;
  logic        frac_mode = 1'b0;
  logic        out_valid;
  logic [39:0] out_prod;

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  // Reference state: what the outputs must show after the next edge.
  logic        exp_valid = 1'b0;
  logic [39:0] exp_prod  = '0;
  string       exp_tag   = "R1";

  always #5 clk = ~clk;

  mxm_top u_mxm_top (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .a_data (a_data), .b_data (b_data),
    .a_signed (a_signed), .b_signed (b_signed), .frac_mode (frac_mode),
    .out_valid (out_valid), .out_prod (out_prod)
  );

  function automatic logic [39:0] ref_product(logic [15:0] a, logic [15:0] b,
                                              logic as, logic bs, logic fr);
    longint va, vb, p;
    va = as ? longint'($signed(a)) : longint'(a);
    vb = bs ? longint'($signed(b)) : longint'(b);
    p  = va * vb;
    if (fr) p = p * 2;
    return p[39:0];
  endfunction

  function automatic string mode_tag(logic a, logic b, logic as, logic bs, logic fr);
    if (a == 1'b1) return "R9";
    if (fr) return "R6";
    if (as && bs) return "R3";
    if (!as && !bs) return "R4";
    return "R5";
  endfunction

  task automatic check40(string tag, logic [39:0] act, logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_prod actual=%010h expected=%010h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_valid actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Compare at the falling edge, then apply the next stimulus.
  task automatic step(logic v, logic [15:0] a, logic [15:0] b,
                      logic as, logic bs, logic fr, string force_tag);
    @(negedge clk);
    check1("R2", out_valid, exp_valid);
    check40(exp_tag, out_prod, exp_prod);
    in_valid = v; a_data = a; b_data = b;
    a_signed = as; b_signed = bs; frac_mode = fr;
    exp_valid = v;
    if (v) begin
      exp_prod = ref_product(a, b, as, bs, fr);
      exp_tag  = (force_tag != "") ? force_tag
               : mode_tag((a == 16'h0) || (b == 16'h0), 1'b0, as, bs, fr);
    end else begin
      exp_tag = "R8";
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a valid request held during reset.
    in_valid = 1'b1; a_data = 16'h1234; b_data = 16'h5678;
    repeat (3) begin
      @(negedge clk);
      check1("R1", out_valid, 1'b0);
      check40("R1", out_prod, 40'h0);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    exp_valid = 1'b0; exp_prod = '0; exp_tag = "R1";

    // Corner cases.
    step(1, 16'h8000, 16'h8000, 1, 1, 1, "R7");   // -1.0 x -1.0 -> 0x0080000000
    step(1, 16'h8000, 16'h8000, 1, 1, 0, "R3");   // integer 0x40000000
    step(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R4");   // 0xFFFE0001
    step(1, 16'hFFFF, 16'hFFFF, 1, 1, 0, "R3");   // +1
    step(1, 16'hFFFF, 16'hFFFF, 1, 0, 0, "R5");   // -65535
    step(1, 16'hFFFF, 16'hFFFF, 0, 1, 0, "R5");   // -65535
    step(1, 16'hFFFF, 16'hFFFF, 0, 0, 1, "R6");   // 0x1FFFC0002
    step(1, 16'h8000, 16'h7FFF, 1, 1, 1, "R6");
    step(0, 16'h1111, 16'h2222, 1, 1, 1, "");     // idle: hold
    step(0, 16'hFFFF, 16'h0001, 0, 0, 0, "");
    for (int m = 0; m < 8; m++) begin
      step(1, 16'h0000, 16'hFFFF, m[0], m[1], m[2], "R9");
      step(1, 16'h8000, 16'h0000, m[0], m[1], m[2], "R9");
    end

    // Random traffic over every mode combination, with idle gaps.
    for (int i = 0; i < 4000; i++) begin
      logic v;
      logic [15:0] ra, rb;
      v  = ($urandom_range(0, 3) != 0);
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (i % 17 == 0) ra = 16'h8000;
      if (i % 23 == 0) rb = 16'hFFFF;
      step(v, ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), "");
    end
    step(0, 16'h0, 16'h0, 0, 0, 0, "");
    step(0, 16'h0, 16'h0, 0, 0, 0, "");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule